// File: doc/BRIEF.md
# Normalized Digit-Serial Long Divider

This block divides an unsigned dividend by an unsigned divisor and returns both the quotient and the remainder. Both operands are handled as strings of 16-bit digits. The block produces one quotient digit per step, in the way long division is done by hand, and it does not work one bit at a time. Before it starts, it shifts both operands left by the same amount. The amount is chosen so that the leading non-zero digit of the divisor has its top bit set. Each quotient digit is then guessed from the two leading digits of the running remainder and the leading divisor digit. Because the divisor is normalized, the guess is never low and is never more than two too high, so a few subtract-back steps correct it. When the last digit is done, the running remainder is shifted right by the normalizing amount to give the true remainder.

A caller drives the operands and pulses `start` while the block is idle. The operands are captured at that edge. `busy` then stays high while the divide runs, and `done` goes high for one cycle when `quotient` and `remainder` are valid. The results hold until the next accepted start. A zero divisor skips the iteration entirely and raises `div_by_zero`.

The control flow has seven states:
- IDLE waits for start. On start it goes to NORM, or to DONE when the divisor is zero.
- NORM finds the leading divisor digit and the shift amount, shifts both operands, and goes to SHIFT.
- SHIFT brings the next dividend digit into the running remainder and goes to EST.
- EST forms the capped digit guess and its product with the divisor, and goes to FIX.
- FIX has two transitions. It loops on itself while the product exceeds the running remainder, lowering the guess each time. Otherwise it subtracts the product, commits the digit, and goes to SHIFT, or to UNNORM after the lowest digit.
- UNNORM shifts the remainder back and goes to DONE.
- DONE pulses `done` and returns to IDLE.

Top module: `normdiv_top`

## Requirements
- R1: During and right after reset, `busy`, `done` and `div_by_zero` are low and `quotient` and `remainder` are zero.
- R2: A start accepted in idle with a non-zero divisor raises `busy` in the next cycle. `done` rises within 27 clock edges of the start edge and lasts exactly one cycle. `busy` and `done` are never high together.
- R3: With a non-zero divisor, `quotient` equals the integer floor of dividend divided by divisor. Each digit committed in FIX is exact, meaning the remaining partial remainder is below the normalized divisor.
- R4: With a non-zero divisor, `remainder` equals dividend modulo divisor, is below the divisor, and `div_by_zero` is low.
- R5: A zero divisor sets `done` and `div_by_zero` in the cycle right after the start edge, never raises `busy`, and returns a zero quotient and a zero remainder.
- R6: Divisors whose leading non-zero digit already has its top bit set (shift of zero) are handled correctly. So are single-digit divisors and divisors where the normalizing shift pushes dividend bits into the extra top digit.
- R7: No more than two corrections are applied to any quotient digit guess.
- R8: Operands are captured at the accepted start edge. Changes to `dividend` and `divisor`, and `start` pulses, while `busy` is high have no effect on the results.
- R9: After `done`, `quotient` and `remainder` stay unchanged while the block is idle and no start arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a divide; taken only in idle |
| dividend | input | 64 | Unsigned dividend, four 16-bit digits |
| divisor | input | 32 | Unsigned divisor, two 16-bit digits |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle pulse, results valid |
| div_by_zero | output | 1 | Last divide had a zero divisor |
| quotient | output | 64 | Quotient of the last divide |
| remainder | output | 32 | Remainder of the last divide |

## Verification
A wrong normalizing shift or a wrong leading-digit choice shows up directly at the ports. It leaves a digit guess that is too small, so the quotient comes out short and the remainder at or above the divisor in the same cycle that `done` rises. A mistake in the correction loop or in the digit counter either changes the result or moves the `done` pulse outside its latency window, so the fault appears at the end of that one operation. An error in the un-normalizing shift affects only the remainder. Single-digit divisors, divisors that are already normalized, and operands that spill bits into the extra dividend digit are all driven to expose these faults.

// File: rtl/normdiv_pkg.sv
package normdiv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NORM,
        ST_SHIFT,
        ST_EST,
        ST_FIX,
        ST_UNNORM,
        ST_DONE
    } nd_state_e;

endpackage

// File: rtl/normdiv_lead_scan.sv
// Finds the most significant non-zero divisor digit and the number of
// leading zero bits inside it (the normalizing shift).
module normdiv_lead_scan #(
    parameter int DIGIT_W = 16,
    parameter int DEN_DIG = 2,
    localparam int DEN_W  = DIGIT_W * DEN_DIG,
    localparam int IDX_W  = (DEN_DIG > 1) ? $clog2(DEN_DIG) : 1,
    localparam int SH_W   = (DIGIT_W > 1) ? $clog2(DIGIT_W) : 1
) (
    input  logic [DEN_W-1:0]   den,
    output logic [IDX_W-1:0]   lead_idx,
    output logic [SH_W-1:0]    shift
);

    logic [DIGIT_W-1:0] top_digit;
    logic               seen_one;

    always_comb begin
        lead_idx = '0;
        for (int i = 0; i < DEN_DIG; i++) begin
            if (den[i*DIGIT_W +: DIGIT_W] != '0) begin
                lead_idx = IDX_W'(i);
            end
        end
    end

    assign top_digit = den[int'(lead_idx)*DIGIT_W +: DIGIT_W];

    always_comb begin
        shift    = '0;
        seen_one = 1'b0;
        for (int b = DIGIT_W - 1; b >= 0; b--) begin
            if (!seen_one) begin
                if (top_digit[b]) begin
                    seen_one = 1'b1;
                end else if (b != 0) begin
                    shift = shift + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/normdiv_qest.sv
// Guesses one quotient digit from the two leading digits of the running
// remainder and the leading digit of the normalized divisor, capped at
// the largest digit value.
module normdiv_qest #(
    parameter int DIGIT_W = 16,
    parameter int DEN_DIG = 2,
    localparam int DEN_W  = DIGIT_W * DEN_DIG,
    localparam int REM_W  = DEN_W + DIGIT_W,
    localparam int IDX_W  = (DEN_DIG > 1) ? $clog2(DEN_DIG) : 1
) (
    input  logic [REM_W-1:0]   part_rem,
    input  logic [DEN_W-1:0]   norm_den,
    input  logic [IDX_W-1:0]   lead_idx,
    output logic [DIGIT_W-1:0] qhat
);

    logic [2*DIGIT_W-1:0] top_pair;
    logic [DIGIT_W-1:0]   den_top;
    logic [2*DIGIT_W-1:0] raw_q;

    assign top_pair = part_rem[int'(lead_idx)*DIGIT_W +: 2*DIGIT_W];
    assign den_top  = norm_den[int'(lead_idx)*DIGIT_W +: DIGIT_W];

    always_comb begin
        if (den_top == '0) begin
            raw_q = '1;
        end else begin
            raw_q = top_pair / {{DIGIT_W{1'b0}}, den_top};
        end
        if (raw_q[2*DIGIT_W-1:DIGIT_W] != '0) begin
            qhat = '1;
        end else begin
            qhat = raw_q[DIGIT_W-1:0];
        end
    end

endmodule

// File: rtl/normdiv_top.sv
module normdiv_top
    import normdiv_pkg::*;
#(
    parameter int DIGIT_W = 16,
    parameter int NUM_DIG = 4,
    parameter int DEN_DIG = 2,
    localparam int NUM_W  = DIGIT_W * NUM_DIG,
    localparam int DEN_W  = DIGIT_W * DEN_DIG,
    localparam int EXT_W  = NUM_W + DIGIT_W,
    localparam int REM_W  = DEN_W + DIGIT_W,
    localparam int IDX_W  = (DEN_DIG > 1) ? $clog2(DEN_DIG) : 1,
    localparam int SH_W   = (DIGIT_W > 1) ? $clog2(DIGIT_W) : 1,
    localparam int DIG_W  = $clog2(NUM_DIG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] dividend,
    input  logic [DEN_W-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic             div_by_zero,
    output logic [NUM_W-1:0] quotient,
    output logic [DEN_W-1:0] remainder
);

    nd_state_e state_q, state_d;

    logic [EXT_W-1:0]   num_q;
    logic [DEN_W-1:0]   den_q;
    logic [DEN_W-1:0]   vden_q;
    logic [SH_W-1:0]    shift_q;
    logic [IDX_W-1:0]   lead_q;
    logic [REM_W-1:0]   rem_q;
    logic [REM_W-1:0]   prod_q;
    logic [DIGIT_W-1:0] qhat_q;
    logic [NUM_W-1:0]   quo_q;
    logic [DIG_W-1:0]   dig_q;
    logic [1:0]         corr_q;
    logic               dz_q;
    logic [NUM_W-1:0]   quo_out_q;
    logic [DEN_W-1:0]   rem_out_q;

    logic [IDX_W-1:0]   lead_w;
    logic [SH_W-1:0]    shift_w;
    logic [DIGIT_W-1:0] qhat_w;
    logic               too_big;

    normdiv_lead_scan #(.DIGIT_W(DIGIT_W), .DEN_DIG(DEN_DIG)) u_scan (
        .den      (den_q),
        .lead_idx (lead_w),
        .shift    (shift_w)
    );

    normdiv_qest #(.DIGIT_W(DIGIT_W), .DEN_DIG(DEN_DIG)) u_qest (
        .part_rem (rem_q),
        .norm_den (vden_q),
        .lead_idx (lead_q),
        .qhat     (qhat_w)
    );

    assign too_big = (prod_q > rem_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (divisor == '0) ? ST_DONE : ST_NORM;
                end
            end
            ST_NORM:   state_d = ST_SHIFT;
            ST_SHIFT:  state_d = ST_EST;
            ST_EST:    state_d = ST_FIX;
            ST_FIX: begin
                if (!too_big) begin
                    state_d = (dig_q == '0) ? ST_UNNORM : ST_SHIFT;
                end
            end
            ST_UNNORM: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            num_q     <= '0;
            den_q     <= '0;
            vden_q    <= '0;
            shift_q   <= '0;
            lead_q    <= '0;
            rem_q     <= '0;
            prod_q    <= '0;
            qhat_q    <= '0;
            quo_q     <= '0;
            dig_q     <= '0;
            corr_q    <= '0;
            dz_q      <= 1'b0;
            quo_out_q <= '0;
            rem_out_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        num_q <= {{DIGIT_W{1'b0}}, dividend};
                        den_q <= divisor;
                        dz_q  <= (divisor == '0);
                        if (divisor == '0) begin
                            quo_out_q <= '0;
                            rem_out_q <= '0;
                        end
                    end
                end
                ST_NORM: begin
                    num_q   <= num_q << shift_w;
                    vden_q  <= den_q << shift_w;
                    shift_q <= shift_w;
                    lead_q  <= lead_w;
                    rem_q   <= '0;
                    quo_q   <= '0;
                    dig_q   <= DIG_W'(NUM_DIG);
                end
                ST_SHIFT: begin
                    rem_q <= {rem_q[REM_W-DIGIT_W-1:0],
                              num_q[int'(dig_q)*DIGIT_W +: DIGIT_W]};
                end
                ST_EST: begin
                    qhat_q <= qhat_w;
                    prod_q <= REM_W'(qhat_w) * REM_W'(vden_q);
                    corr_q <= '0;
                end
                ST_FIX: begin
                    if (too_big) begin
                        qhat_q <= qhat_q - 1'b1;
                        prod_q <= prod_q - REM_W'(vden_q);
                        corr_q <= corr_q + 1'b1;
                    end else begin
                        rem_q <= rem_q - prod_q;
                        quo_q <= {quo_q[NUM_W-DIGIT_W-1:0], qhat_q};
                        if (dig_q != '0) begin
                            dig_q <= dig_q - 1'b1;
                        end
                    end
                end
                ST_UNNORM: begin
                    quo_out_q <= quo_q;
                    rem_out_q <= DEN_W'(rem_q >> shift_q);
                end
                ST_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy        = (state_q != ST_IDLE) && (state_q != ST_DONE);
        done        = (state_q == ST_DONE);
        div_by_zero = dz_q;
        quotient    = quo_out_q;
        remainder   = rem_out_q;
    end

    // Assertions
    assert_busy_done_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_digit_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIX && !too_big) |-> ((rem_q - prod_q) < REM_W'(vden_q)));

    assert_rem_below_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_by_zero) |-> (remainder < den_q));

    assert_dz_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_by_zero) |-> (quotient == '0 && remainder == '0));

    assert_fix_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIX) |-> (corr_q <= 2'd2));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> ($stable(quotient) && $stable(remainder)));

endmodule

// File: tb/tb_normdiv_top.sv
module tb_normdiv_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        busy, done, div_by_zero;
    logic [63:0] quotient;
    logic [31:0] remainder;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    normdiv_top dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .div_by_zero(div_by_zero),
        .quotient(quotient), .remainder(remainder)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Per-clock protocol monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(!(busy && done), "R2", "busy and done together", {62'd0, busy, done}, 64'd0);
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    // One divide with optional mid-run disturbance (R8)
    task automatic run(input logic [63:0] a, input logic [31:0] b, input bit disturb);
        logic [63:0] eq;
        logic [31:0] er;
        int k;
        eq = (b == 0) ? 64'd0 : a / {32'd0, b};
        er = (b == 0) ? 32'd0 : 32'(a % {32'd0, b});
        @(negedge clk);
        dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (b == 0) begin
            chk(done, "R5", "done right after start", {63'd0, done}, 64'd1);
            chk(div_by_zero, "R5", "div_by_zero", {63'd0, div_by_zero}, 64'd1);
            chk(!busy, "R5", "busy stays low", {63'd0, busy}, 64'd0);
            chk(quotient == 0 && remainder == 0, "R5", "zero results",
                quotient | {32'd0, remainder}, 64'd0);
        end else begin
            chk(busy, "R2", "busy after start", {63'd0, busy}, 64'd1);
            k = 1;
            while (!done && k < 27) begin
                @(negedge clk);
                k++;
                if (disturb && k == 4) begin
                    dividend = ~a; divisor = b ^ 32'h5A5A_0001; start = 1'b1;
                end
                if (disturb && k == 5) start = 1'b0;
            end
            chk(done, "R2", "done within 27 edges", {63'd0, done}, 64'd1);
            chk(quotient == eq, disturb ? "R8" : "R3", "quotient", quotient, eq);
            chk(remainder == er, disturb ? "R8" : "R4", "remainder",
                {32'd0, remainder}, {32'd0, er});
            chk(!div_by_zero, "R4", "div_by_zero low", {63'd0, div_by_zero}, 64'd0);
        end
        @(negedge clk);
        chk(!done, "R2", "done is one cycle", {63'd0, done}, 64'd0);
        dividend = $urandom; divisor = $urandom;
        @(negedge clk);
        chk(quotient == eq && remainder == er, "R9", "results held",
            quotient ^ {32'd0, remainder}, eq ^ {32'd0, er});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] ra;
        logic [31:0] rb;
        // R1: reset state
        #1;
        chk(!busy && !done && !div_by_zero, "R1", "flags in reset",
            {61'd0, busy, done, div_by_zero}, 64'd0);
        chk(quotient == 0 && remainder == 0, "R1", "results in reset",
            quotient | {32'd0, remainder}, 64'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && quotient == 0, "R1", "after reset release",
            {62'd0, busy, done}, 64'd0);

        run(64'd1000, 32'd7, 1'b0);                         // R3 R4 basic
        run(64'd5, 32'd9, 1'b0);                            // dividend below divisor
        run(64'd0, 32'd3, 1'b0);
        run(64'hDEAD_BEEF_0000_1234, 32'd0, 1'b0);          // R5
        run(64'hFFFF_FFFF_FFFF_FFFF, 32'd1, 1'b0);          // R6 single digit
        run(64'hFFFF_FFFF_FFFF_FFFF, 32'h0000_FFFF, 1'b0);  // R6 normalized digit
        run(64'hFFFF_FFFF_FFFF_FFFF, 32'h8000_0000, 1'b0);  // R6 no shift
        run(64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run(64'h8000_0000_0000_0000, 32'h0001_FFFF, 1'b0);  // R6 spill + corrections
        run(64'h7FFF_8000_0000_0000, 32'h0000_8001, 1'b0);
        run(64'h0001_0000_FFFF_FFFE, 32'h0001_0000, 1'b0);
        run(64'h1234_5678_9ABC_DEF0, 32'h0000_0003, 1'b1);  // R8 disturbance
        run(64'hFFFF_0000_FFFF_0000, 32'd0, 1'b0);          // R5 again

        for (int i = 0; i < 40; i++) begin
            ra = {$urandom, $urandom};
            rb = $urandom;
            case (i % 4)
                0: rb = rb & 32'h0000_FFFF;
                1: rb = rb | 32'h8000_0000;
                2: rb = rb & 32'h0003_FFFF;
                default: ;
            endcase
            if (rb == 0) rb = 32'd11;
            run(ra, rb, 1'b0);                              // R3 R4 random
        end
        finish_run();
    end

endmodule